// File: doc/BRIEF.md
# Four-Bank Low-Order Interleaved Memory Controller

This block takes one stream of word requests on a valid/ready port and spreads it over four independent memory banks. The two lowest address bits choose the bank, and the remaining upper bits address a word inside that bank. As a result, consecutive addresses fall into different banks, and their accesses overlap in time. Each bank stays occupied for a parameterised number of cycles per access. The request port, by contrast, can hand a new request to a different bank on every clock.

Read results come back on a single return port, in the order the reads were accepted. This holds even when a later read to a faster-freeing bank finishes first. A small queue of bank tags records the acceptance order of reads. A bank that has finished a read keeps its result, and stays unavailable, until that result has been returned. Writes update the bank storage and return nothing. The bank storage is a plain behavioural array inside the block.

Top module: `ilv_mem_ctrl`

## Requirements
- R1: The bank is chosen by address bits [1:0]: bank k holds every address equal to k modulo 4.
- R2: Inside a bank, a word is located by the address shifted right by two. Writing every address and reading each back returns the data written to that exact address.
- R3: When the banks are idle, requests to four different banks are accepted on four consecutive clocks with no stall.
- R4: After a write is accepted to a bank, `req_ready` stays low for further requests to that bank during the next LAT clocks. The next request to that bank is accepted on the (LAT+1)-th clock after the write.
- R5: For an isolated read accepted on clock edge t, `rsp_valid` is high for one cycle after edge t+LAT+1, carrying the read data.
- R6: Read data is returned in exactly the order the reads were accepted, whatever banks they used. At most four reads are ever outstanding.
- R7: An accepted write never causes a beat on `rsp_valid`.
- R8: After a read is accepted to a bank, the next request to that bank waits LAT+1 clocks, because the bank holds its result until the result is returned.
- R9: During and right after reset, `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | The addressed bank can take the request this cycle |
| req_addr | input | ADDR_W | Word address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data beat |
| rsp_data | output | DATA_W | Read data |

## Verification
The bench first writes every address in ascending order, so the bank index rotates each clock; it then reads every address back in that order and in a descending four-address order. Together these separate a wrong bank select or a wrong bank-internal address from a reordering fault in the return path. Back-to-back requests to one bank, once a write and once a read, measure the stall lengths, which tell the write occupancy apart from the read-hold occupancy. A lone read measures the return latency. A long pseudo-random mix of reads and writes then checks read-after-write to the same word and in-order return under irregular bank conflicts.

// File: rtl/ilv_mem_ctrl.sv
module ilv_mem_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LAT    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int NB    = 4;
  localparam int BA_W  = ADDR_W - 2;
  localparam int DEPTH = 1 << BA_W;
  localparam int CW    = $clog2(LAT + 1) + 1;

  logic [1:0]        bsel;
  logic              accept, push, pop;
  logic [CW-1:0]     cnt    [NB];
  logic              hold   [NB];
  logic              b_we   [NB];
  logic [BA_W-1:0]   b_addr [NB];
  logic [DATA_W-1:0] b_wd   [NB];
  logic [DATA_W-1:0] b_rd   [NB];

  logic [1:0] tq [NB];
  logic [1:0] wp, rp, head;
  logic [2:0] qcnt;

  assign bsel      = req_addr[1:0];
  assign req_ready = (cnt[bsel] == '0) && !hold[bsel];
  assign accept    = req_valid && req_ready;
  assign push      = accept && !req_we;
  assign head      = tq[rp];
  assign pop       = (qcnt != '0) && hold[head];

  for (genvar i = 0; i < NB; i++) begin : g_bank
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt[i]    <= '0;
        hold[i]   <= 1'b0;
        b_we[i]   <= 1'b0;
        b_addr[i] <= '0;
        b_wd[i]   <= '0;
      end else begin
        if (accept && bsel == 2'(i)) begin
          cnt[i]    <= CW'(LAT);
          b_we[i]   <= req_we;
          b_addr[i] <= req_addr[ADDR_W-1:2];
          b_wd[i]   <= req_wdata;
        end else if (cnt[i] != '0) begin
          cnt[i] <= cnt[i] - 1'b1;
        end
        if (cnt[i] == CW'(1) && !b_we[i]) hold[i] <= 1'b1;
        else if (pop && head == 2'(i))    hold[i] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (cnt[i] == CW'(1)) begin
        if (b_we[i]) mem[b_addr[i]] <= b_wd[i];
        else         b_rd[i] <= mem[b_addr[i]];
      end
    end

    a_r4_bank_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && bsel == 2'(i)) |=> (cnt[i] == CW'(LAT)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; qcnt <= '0;
      rsp_valid <= 1'b0; rsp_data <= '0;
      for (int k = 0; k < NB; k++) tq[k] <= '0;
    end else begin
      if (push) begin
        tq[wp] <= bsel;
        wp <= wp + 1'b1;
      end
      if (pop) rp <= rp + 1'b1;
      qcnt <= qcnt + {2'b0, push} - {2'b0, pop};
      rsp_valid <= pop;
      if (pop) rsp_data <= b_rd[head];
    end
  end

  a_r6_tag_bound: assert property (@(posedge clk) disable iff (!rst_n)
    qcnt <= 3'(NB));
  a_r6_rsp_has_tag: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(qcnt) != '0));
  a_r7_write_no_tag: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_we) |=> (qcnt <= $past(qcnt)));
  a_r9_quiet_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (qcnt == '0) |=> !rsp_valid);
endmodule

// File: tb/ilv_mem_ctrl_tb_top.sv
module ilv_mem_ctrl_tb_top;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int LAT    = 4;
  localparam int NA     = 1 << ADDR_W;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0, req_ready, rsp_valid;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0, rsp_data;

  always #2 clk = ~clk;

  ilv_mem_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data));

  int checks = 0, fails = 0, beats = 0;
  logic [DATA_W-1:0] refmem [NA];
  logic [DATA_W-1:0] expq [$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] pat(input int a, input int salt);
    return 32'h5A00_0000 ^ (32'(a) * 32'h0101_0107) ^ 32'(salt);
  endfunction

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      beats++;
      if (expq.size() == 0) chk(0, "R6 unexpected beat", rsp_data, 0);
      else begin
        logic [DATA_W-1:0] e;
        e = expq.pop_front();
        chk(rsp_data == e, "R1/R2/R6 read data", rsp_data, e);
      end
    end
  end

  task automatic send(input int a, input bit we, input logic [DATA_W-1:0] d, output int waits);
    waits = 0;
    @(negedge clk);
    req_valid = 1; req_addr = ADDR_W'(a); req_we = we; req_wdata = d;
    #1;
    while (!req_ready) begin
      waits++;
      @(negedge clk);
      #1;
    end
    if (we) refmem[a] = d;
    else    expq.push_back(refmem[a]);
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int w, n;
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    #1;
    chk(req_ready == 1, "R9 ready in reset", req_ready, 1);
    chk(rsp_valid == 0, "R9 rsp in reset", rsp_valid, 0);
    rst_n = 1;
    @(negedge clk); #1;
    chk(req_ready == 1 && rsp_valid == 0, "R9 after reset", {req_ready, rsp_valid}, 2'b10);

    // R7: write every address, no beats
    for (int a = 0; a < NA; a++) send(a, 1, pat(a, 0), w);
    idle(2 * LAT);
    chk(beats == 0, "R7 writes gave beats", beats, 0);

    // R3: four banks back to back
    for (int a = 0; a < 4; a++) begin
      send(a, 0, '0, w);
      chk(w == 0, "R3 distinct-bank stall", w, 0);
    end
    idle(2 * LAT);

    // R1/R2/R6: full readback, then descending order in groups
    for (int a = 4; a < NA; a++) send(a, 0, '0, w);
    for (int g = NA / 4 - 1; g >= 0; g--)
      for (int k = 3; k >= 0; k--) send(g * 4 + k, 0, '0, w);
    idle(3 * LAT);
    chk(expq.size() == 0, "R6 all reads returned", expq.size(), 0);

    // R4: write then same-bank request
    send(8, 1, 32'hCAFE_0008, w);
    send(12, 1, 32'hCAFE_000C, w);
    chk(w == LAT, "R4 write occupancy", w, LAT);
    idle(2 * LAT);

    // R8: read then same-bank request
    send(9, 0, '0, w);
    send(13, 0, '0, w);
    chk(w == LAT + 1, "R8 read hold occupancy", w, LAT + 1);
    idle(3 * LAT);

    // R5: isolated read latency
    send(6, 0, '0, w);
    idle(0);
    n = 1;
    while (!rsp_valid && n < 30) begin
      @(negedge clk);
      n++;
    end
    chk(n == LAT + 2, "R5 read latency", n, LAT + 2);
    idle(2 * LAT);

    // Read after write to same word
    send(21, 1, 32'h1234_5678, w);
    send(21, 0, '0, w);
    idle(3 * LAT);

    // Random mix
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send(int'(lfsr[7:0]), lfsr[8] & lfsr[11], pat(int'(lfsr[7:0]), i), w);
    end
    idle(4 * LAT);
    chk(expq.size() == 0, "R6 random reads returned", expq.size(), 0);
    finish_run();
  end
endmodule